// File: doc/BRIEF.md
# Fast Ethernet Line Code Converter

This block converts between 5-bit code groups and the three-level line signal of a 100 Mb/s twisted-pair PHY. It runs on the 125 MHz bit clock. On the transmit side it takes one scrambled code group every five bit times and serializes it. The serial stream passes through an NRZI encoder and then an MLT-3 mapper, which drives a signed two-bit line level.

The receive side runs the same chain in reverse. Each incoming level is compared with the one before it to recover the NRZI stream. An NRZI decoder turns that stream back into NRZ bits, and a packer gathers five bits into a group. Equalization, clock recovery, scrambling and symbol alignment are done elsewhere. An alignment strobe from outside marks the first bit of each receive group.

A single control input enables NRZI coding. When it is low, the NRZI stage is bypassed in both directions.

Top module: `lcc_line_codec`

## Requirements
- R1: `tx_take` is high in the first cycle after reset and then in every fifth cycle. `tx_group` is captured on the clock edge that ends a cycle in which `tx_take` is high.
- R2: A captured group is sent least significant bit first. Bit k of a group captured at edge E enters the serial stream at edge E+k, and its effect reaches `tx_level` at edge E+k+2.
- R3: With `nrzi_en`=1, the transmit NRZI line bit toggles on a serial 1 and holds on a serial 0.
- R4: With `nrzi_en`=0, the NRZI stage passes the bit through unchanged in both the transmit and the receive path.
- R5: `tx_level` uses the encoding +1=2'b01, 0=2'b00, -1=2'b11. From reset it steps through 0, +1, 0, -1 and then repeats. It advances one step on each 1 at its input and holds on a 0, so it never jumps directly between +1 and -1.
- R6: After reset, `tx_level` is 0, `tx_take` is 1, `rx_valid` is 0 and `rx_group` is 0.
- R7: The receive MLT-3 decoder outputs 1 when `rx_level` differs from the level sampled one cycle earlier, and 0 otherwise. The level before the first sample counts as 0.
- R8: With `nrzi_en`=1, the receive NRZI decoder outputs the XOR of the current and the previous recovered line bits. The line bit before the first sample counts as 0.
- R9: The level sampled together with `rx_align`=1 carries bit 0 of a group, and the next four samples fill bits 1 to 4. `rx_group` and a one-cycle `rx_valid` pulse appear 6 cycles after the edge that sampled bit 0.
- R10: An `rx_align` that arrives while a group is still being filled abandons that group and starts a new one.
- R11: Once a group is complete, no further `rx_valid` pulse comes until the next `rx_align`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrzi_en | input | 1 | 1 enables NRZI encoding and decoding; 0 bypasses both |
| tx_group | input | 5 | Transmit code group |
| tx_take | output | 1 | High in the cycle whose closing edge captures `tx_group` |
| tx_level | output | 2 | Signed MLT-3 transmit level |
| rx_level | input | 2 | Signed MLT-3 receive level |
| rx_align | input | 1 | Marks the receive sample that carries bit 0 of a group |
| rx_group | output | 5 | Last completed receive group |
| rx_valid | output | 1 | One-cycle pulse when `rx_group` updates |

## Verification
The transmit path has three registers: the serializer, the NRZI encoder and the MLT-3 step counter. A group bit therefore affects `tx_level` two edges after it enters the serial stream. The bench model advances its own serial, NRZI and step state in that same order each cycle and compares `tx_level` one cycle at a time.

On the receive side, a group is due 6 edges after its bit 0 is sampled. The bench builds the whole stream of levels and strobes ahead of time. At each half-cycle point it works out whether a pulse is due from the strobe six samples back and the four samples after it, and computes each group bit from the level samples themselves.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef logic signed [1:0] lvl_t;

  localparam lvl_t LVL_POS  = 2'sb01;
  localparam lvl_t LVL_ZERO = 2'sb00;
  localparam lvl_t LVL_NEG  = 2'sb11;

  // Line level for a position in the four-step MLT-3 cycle.
  function automatic lvl_t mlt3_level(input logic [1:0] step);
    case (step)
      2'd1:    return LVL_POS;
      2'd3:    return LVL_NEG;
      default: return LVL_ZERO;
    endcase
  endfunction

  // One NRZI encode step: toggle on 1 when enabled, plain copy when bypassed.
  function automatic logic nrzi_enc_step(input logic line, input logic bit_in,
                                         input logic en);
    return en ? (line ^ bit_in) : bit_in;
  endfunction

  // One NRZI decode step from two consecutive line bits.
  function automatic logic nrzi_dec_step(input logic cur, input logic prev,
                                         input logic en);
    return en ? (cur ^ prev) : cur;
  endfunction

  // MLT-3 receive decision: a change of level means a 1.
  function automatic logic mlt3_changed(input lvl_t cur, input lvl_t prev);
    return cur != prev;
  endfunction
endpackage

// File: rtl/lcc_nrzi.sv
module lcc_nrzi #(
  parameter bit DECODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_in,
  output logic bit_out
);
  import lcc_pkg::*;

  logic out_q;
  assign bit_out = out_q;

  generate
    if (DECODE == 1'b0) begin : g_enc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= nrzi_enc_step(out_q, bit_in, en);
      end

      // R3
      enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_in) |=> $stable(out_q));
      // R3
      enc_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_in) |=> (out_q != $past(out_q)));
      // R4
      enc_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_q == $past(bit_in)));
    end else begin : g_dec
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          out_q  <= 1'b0;
        end else begin
          prev_q <= bit_in;
          out_q  <= nrzi_dec_step(bit_in, prev_q, en);
        end
      end

      // R8
      dec_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && (bit_in == prev_q)) |=> !out_q);
      // R4
      dec_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_q == $past(bit_in)));
    end
  endgenerate
endmodule

// File: rtl/lcc_tx_chain.sv
module lcc_tx_chain #(
  parameter int GROUP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nrzi_en,
  input  logic [GROUP_W-1:0] group_in,
  output logic               take,
  output lcc_pkg::lvl_t      level_out
);
  import lcc_pkg::*;

  localparam int CNT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;

  logic [CNT_W-1:0]   ph_q;
  logic [GROUP_W-1:0] shreg_q;
  logic               ser_q;
  logic               line_bit;
  logic [1:0]         step_q;

  wire ph_last  = (ph_q == CNT_W'(GROUP_W - 1));
  wire mlt3_adv = line_bit;

  assign take      = (ph_q == '0);
  assign level_out = mlt3_level(step_q);

  // Serializer: LSB leaves on the capture edge, the rest shift out after it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      shreg_q <= '0;
      ser_q   <= 1'b0;
    end else begin
      ph_q <= ph_last ? '0 : ph_q + 1'b1;
      if (take) begin
        ser_q   <= group_in[0];
        shreg_q <= group_in >> 1;
      end else begin
        ser_q   <= shreg_q[0];
        shreg_q <= shreg_q >> 1;
      end
    end
  end

  lcc_nrzi #(.DECODE(1'b0)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (nrzi_en),
    .bit_in (ser_q),
    .bit_out(line_bit)
  );

  // MLT-3 mapper: step position in the 0,+1,0,-1 cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= 2'd0;
    else        step_q <= step_q + {1'b0, mlt3_adv};
  end

  // R1
  take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);
  // R2
  lsb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ser_q == $past(group_in[0])));
  // R5
  mlt3_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mlt3_adv |=> $stable(level_out));
  // R5
  mlt3_no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_out == LVL_POS) |=> (level_out != LVL_NEG));
  // R5
  mlt3_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_out != 2'sb10);
endmodule

// File: rtl/lcc_packer.sv
module lcc_packer #(
  parameter int GROUP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_in,
  input  logic               start,
  output logic [GROUP_W-1:0] group_out,
  output logic               valid
);
  localparam int CNT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;

  logic [CNT_W-1:0]   cnt_q;
  logic [GROUP_W-1:0] acc_q;
  logic [GROUP_W-1:0] grp_q;
  logic               valid_q;

  logic [CNT_W-1:0]   pos;
  logic [GROUP_W-1:0] fill;
  logic               active;
  logic               last;

  always_comb begin
    pos       = start ? '0 : cnt_q;
    active    = start || (cnt_q != '0);
    fill      = start ? '0 : acc_q;
    fill[pos] = bit_in;
    last      = active && (pos == CNT_W'(GROUP_W - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      grp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last;
      if (active) begin
        acc_q <= fill;
        cnt_q <= last ? '0 : pos + 1'b1;
      end
      if (last) grp_q <= fill;
    end
  end

  assign group_out = grp_q;
  assign valid     = valid_q;

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (GROUP_W > 1)) |=> (cnt_q == CNT_W'(1)));
  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == '0) && !start) |=> !valid);
endmodule

// File: rtl/lcc_rx_chain.sv
module lcc_rx_chain #(
  parameter int GROUP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               nrzi_en,
  input  lcc_pkg::lvl_t      level_in,
  input  logic               align,
  output logic [GROUP_W-1:0] group_out,
  output logic               valid
);
  import lcc_pkg::*;

  lvl_t prev_lvl_q;
  logic mlt3_bit_q;
  logic nrz_bit;
  logic align_d1_q;
  logic align_d2_q;

  wire level_moved = mlt3_changed(level_in, prev_lvl_q);

  // MLT-3 to NRZI, with the strobe delayed to stay beside its bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_lvl_q <= LVL_ZERO;
      mlt3_bit_q <= 1'b0;
      align_d1_q <= 1'b0;
      align_d2_q <= 1'b0;
    end else begin
      prev_lvl_q <= level_in;
      mlt3_bit_q <= level_moved;
      align_d1_q <= align;
      align_d2_q <= align_d1_q;
    end
  end

  lcc_nrzi #(.DECODE(1'b1)) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (nrzi_en),
    .bit_in (mlt3_bit_q),
    .bit_out(nrz_bit)
  );

  lcc_packer #(.GROUP_W(GROUP_W)) u_pack (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (nrz_bit),
    .start    (align_d2_q),
    .group_out(group_out),
    .valid    (valid)
  );

  // R7
  mlt3_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_in == prev_lvl_q) |=> !mlt3_bit_q);
  // R7
  mlt3_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_in != prev_lvl_q) |=> mlt3_bit_q);
endmodule

// File: rtl/lcc_line_codec.sv
module lcc_line_codec #(
  parameter int GROUP_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                nrzi_en,
  input  logic [GROUP_W-1:0]  tx_group,
  output logic                tx_take,
  output logic signed [1:0]   tx_level,
  input  logic signed [1:0]   rx_level,
  input  logic                rx_align,
  output logic [GROUP_W-1:0]  rx_group,
  output logic                rx_valid
);
  lcc_tx_chain #(.GROUP_W(GROUP_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .nrzi_en  (nrzi_en),
    .group_in (tx_group),
    .take     (tx_take),
    .level_out(tx_level)
  );

  lcc_rx_chain #(.GROUP_W(GROUP_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .nrzi_en  (nrzi_en),
    .level_in (rx_level),
    .align    (rx_align),
    .group_out(rx_group),
    .valid    (rx_valid)
  );
endmodule

// File: tb/lcc_line_codec_test.sv
module lcc_line_codec_test;
  localparam int N  = 300;
  localparam int NG = N / 5 + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              nrzi_en = 1'b1;
  logic [4:0]        tx_group = '0;
  logic              tx_take;
  logic signed [1:0] tx_level;
  logic signed [1:0] rx_level = '0;
  logic              rx_align = 1'b0;
  logic [4:0]        rx_group;
  logic              rx_valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic signed [1:0] lv [0:N+1];
  bit                al [0:N+1];
  logic [4:0]        grp [0:NG-1];

  always #10 clk = ~clk;

  lcc_line_codec uut (
    .clk(clk), .rst_n(rst_n), .nrzi_en(nrzi_en),
    .tx_group(tx_group), .tx_take(tx_take), .tx_level(tx_level),
    .rx_level(rx_level), .rx_align(rx_align),
    .rx_group(rx_group), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Level after a number of advances, counted around 0,+1,0,-1.
  function automatic logic signed [1:0] exp_level(input int adv);
    case (adv % 4)
      1:       return 2'sb01;
      3:       return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction

  function automatic bit moved(input int k);
    if (k < 1) return 1'b0;
    return lv[k] != lv[k-1];
  endfunction

  function automatic bit rx_bit(input int k, input bit en);
    return en ? (moved(k) ^ moved(k-1)) : moved(k);
  endfunction

  function automatic logic signed [1:0] rnd_level();
    case ($urandom % 3)
      0:       return 2'sb00;
      1:       return 2'sb01;
      default: return 2'sb11;
    endcase
  endfunction

  task automatic run_phase(input bit en, input int off);
    bit s, y, s_n, y_n;
    int adv;
    nrzi_en = en;
    for (int g = 0; g < NG; g++) grp[g] = 5'($urandom);
    grp[0] = 5'h1F; grp[1] = 5'h00; grp[2] = 5'h01; grp[3] = 5'h10;
    lv[0] = 2'sb00; al[0] = 1'b0;
    for (int k = 1; k <= N + 1; k++) begin
      lv[k] = rnd_level();
      al[k] = ((k % 5) == off) && (($urandom % 10) != 0);
      if (($urandom % 25) == 0) al[k] = 1'b1;
    end
    // directed: restart two samples into a group, then a long idle gap
    for (int k = 40; k <= 60; k++) al[k] = 1'b0;
    al[40] = 1'b1; al[42] = 1'b1;
    for (int k = 1; k <= 6; k++) lv[k] = (k % 2) ? 2'sb01 : 2'sb00;

    rst_n = 1'b0; rx_level = '0; rx_align = 1'b0; tx_group = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state
    chk(tx_level == 2'sb00, "R6 tx_level", tx_level, 0);
    chk(tx_take == 1'b1, "R6 tx_take", tx_take, 1);
    chk(rx_valid == 1'b0, "R6 rx_valid", rx_valid, 0);
    chk(rx_group == 5'h00, "R6 rx_group", rx_group, 0);

    s = 1'b0; y = 1'b0; adv = 0;
    for (int n = 0; n <= N; n++) begin
      if (n > 0) begin
        adv = adv + y;
        y_n = en ? (y ^ s) : s;
        s_n = grp[(n-1)/5][(n-1)%5];
        y = y_n; s = s_n;
        // R2 R3 R4 R5: serial order, NRZI and MLT-3 mapping
        chk(tx_level == exp_level(adv), en ? "R5 R3 tx_level" : "R5 R4 tx_level",
            tx_level, exp_level(adv));
        // R1
        chk(tx_take == ((n % 5) == 0), "R1 tx_take", tx_take, (n % 5) == 0);
        begin
          int a = n - 6;
          bit due = 1'b0;
          logic [4:0] eg = '0;
          if (a >= 1 && al[a]) begin
            due = 1'b1;
            for (int j = 1; j <= 4; j++) if (al[a+j]) due = 1'b0;   // R10
          end
          // R9 R11
          chk(rx_valid == due, "R9 R10 R11 rx_valid", rx_valid, due);
          if (due) begin
            for (int j = 0; j < 5; j++) eg[j] = rx_bit(a + j, en);
            // R7 R8 R4 R9
            chk(rx_group == eg, en ? "R7 R8 R9 rx_group" : "R7 R4 R9 rx_group",
                rx_group, eg);
          end
        end
      end
      if ((n % 5) == 0) tx_group = grp[n/5];
      rx_level = lv[n+1];
      rx_align = al[n+1];
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    run_phase(1'b1, 1);
    run_phase(1'b0, 3);
    run_phase(1'b1, 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule